// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a 12-bit charge-balancing successive-approximation converter. Every conversion takes a fixed frame of fifteen clock periods. The first three periods track the input with the comparator auto-zeroed. The remaining twelve periods test one result bit each, from the most significant bit down, and keep or drop each bit according to a synchronous comparator bit. At the close of the last period the finished code moves into an output register, and a data-ready flag is raised. The capacitor array, the comparator, the oscillator and the pad drivers sit outside the block.

Conversions are paced by an active-low start input. Holding start low gives back-to-back conversions. If start is high when period 1 ends, the sequencer parks in period 2. While parked, the input keeps tracking and the ready flag keeps its value. In internal-clock mode the clock-enable output drops so that a gated oscillator can stop. A later low on start resumes the sequence at period 3. The phase machine has three named states:
- TRACK covers periods 1 to 3 and a running period 2.
- PARK is the wait in period 2.
- TRIAL covers periods 4 to 15.

Its transitions are:
- reset→TRACK(1)
- TRACK(1)→TRACK(2) with start low
- TRACK(1)→PARK with start high
- PARK→PARK with start high
- PARK→TRACK(3) with start low
- TRACK(3)→TRIAL(4)
- TRIAL(k)→TRIAL(k+1)
- TRIAL(15)→TRACK(1)

Top module: `sar_sequencer`

## Requirements
- R1: A synchronous active-high reset gives period 1, phase TRACK, result 0, ready low and all trial controls 0.
- R2: While running, the period output steps 1,2,…,15 and then wraps to 1, advancing by one on every rising edge.
- R3: Track and auto-zero controls are high in periods 1 to 3, including the parked period 2, and low in periods 4 to 15.
- R4: In period 4 the trial controls equal 12'h800: bit 11 set, all other bits clear. A trial bit of 1 selects the upper reference.
- R5: Period k (4 to 15) tests bit 15-k. The bit is kept if the comparator is high at the end of that period and cleared otherwise. The next lower bit is then set for its trial. The result is straight binary: with a comparator reporting target ≥ trial controls, the result equals the target, from 0 up to 4095.
- R6: The result register changes only on the edge that ends period 15, and it holds through the whole next conversion.
- R7: The ready flag rises on the edge that ends period 15. It falls on the edge that starts a running period 2, or on the edge that leaves the park.
- R8: If start is high on the edge that ends period 1, the sequencer enters PARK. Period stays 2, tracking stays on and ready keeps its value for as long as start stays high.
- R9: In internal-clock mode (mode input 0) the clock-enable output is low while parked with start high, and it goes high at once when start goes low. In external-clock mode (mode input 1) the clock-enable is always high.
- R10: From PARK, the first rising edge with start low moves to period 3 with tracking still on. The conversion then completes normally.
- R11: With start held low, conversions follow back to back, one result every 15 edges.
- R12: The level of start during periods 2 to 15 of a running conversion has no effect. Only its value at the end of period 1, or while parked, matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low |
| ext_clk_mode | input | 1 | 1 = external clock (enable never dropped), 0 = internal oscillator |
| cmp_hi | input | 1 | Synchronous comparator result, 1 = input above trial level |
| track_en | output | 1 | Connects the array to the input |
| autozero_en | output | 1 | Comparator auto-zero control |
| trial_bits | output | 12 | Per-bit reference switch controls, 1 = upper reference |
| dout | output | 12 | Result register, straight binary |
| drdy | output | 1 | Data-ready flag |
| clk_en | output | 1 | Oscillator enable |
| period | output | 4 | Current period 1 to 15 |

## Verification
All outputs other than clk_en are register-based. A change of start or the comparator therefore shows up one rising edge later. The bench drives on the falling edge and samples on the next falling edge. The result and the rising ready flag are due 15 edges after period 1 is observed. After a resume from the park they are due 13 edges after the resume edge. The clock-enable path is combinational from start, so it is checked 1 ns after start changes and with no clock edge in between.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_PARK  = 2'd1,
        ST_TRIAL = 2'd2
    } phase_t;

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int TRACK_PERIODS = 3,
    parameter int NBITS         = 12,
    parameter int PW            = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    input  logic          ext_clk_mode,
    output phase_t        phase,
    output logic [PW-1:0] period,
    output logic          drdy,
    output logic          clk_en,
    output logic          track_en
);

    localparam int            NPER        = TRACK_PERIODS + NBITS;
    localparam logic [PW-1:0] P_ONE       = PW'(1);
    localparam logic [PW-1:0] P_PARK      = PW'(2);
    localparam logic [PW-1:0] P_RESUME    = PW'(3);
    localparam logic [PW-1:0] P_TRACK_END = PW'(TRACK_PERIODS);
    localparam logic [PW-1:0] P_LAST      = PW'(NPER);

    phase_t        phase_q, phase_d;
    logic [PW-1:0] period_q, period_d;
    logic          drdy_q, drdy_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= ST_TRACK;
            period_q <= P_ONE;
            drdy_q   <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            period_q <= period_d;
            drdy_q   <= drdy_d;
        end
    end

    // next-state logic
    always_comb begin
        phase_d  = phase_q;
        period_d = period_q;
        drdy_d   = drdy_q;
        unique case (phase_q)
            ST_TRACK: begin
                if (period_q == P_ONE) begin
                    period_d = P_PARK;
                    if (!start_n) begin
                        drdy_d = 1'b0;
                    end else begin
                        phase_d = ST_PARK;
                    end
                end else if (period_q == P_TRACK_END) begin
                    phase_d  = ST_TRIAL;
                    period_d = period_q + P_ONE;
                end else begin
                    period_d = period_q + P_ONE;
                end
            end
            ST_PARK: begin
                if (!start_n) begin
                    phase_d  = ST_TRACK;
                    period_d = P_RESUME;
                    drdy_d   = 1'b0;
                end
            end
            ST_TRIAL: begin
                if (period_q == P_LAST) begin
                    phase_d  = ST_TRACK;
                    period_d = P_ONE;
                    drdy_d   = 1'b1;
                end else begin
                    period_d = period_q + P_ONE;
                end
            end
            default: begin
                phase_d  = ST_TRACK;
                period_d = P_ONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        phase    = phase_q;
        period   = period_q;
        drdy     = drdy_q;
        track_en = (phase_q != ST_TRIAL);
        clk_en   = ext_clk_mode || (phase_q != ST_PARK) || !start_n;
    end

    a_r2_period_range: assert property (@(posedge clk) disable iff (rst)
        (period_q >= P_ONE) && (period_q <= P_LAST));

    a_r3_track_window: assert property (@(posedge clk) disable iff (rst)
        (phase_q != ST_TRIAL) |-> (period_q <= P_TRACK_END));

    a_r7_ready_rise: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_TRIAL && period_q == P_LAST) |=> (drdy_q && period_q == P_ONE));

    a_r8_park_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_PARK && start_n) |=> (phase_q == ST_PARK && period_q == P_PARK && $stable(drdy_q)));

    a_r10_resume: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_PARK && !start_n) |=> (period_q == P_RESUME && phase_q == ST_TRACK));

endmodule

// File: rtl/sar_bit_trial.sv
module sar_bit_trial
    import sar_seq_pkg::*;
#(
    parameter int NBITS         = 12,
    parameter int TRACK_PERIODS = 3,
    parameter int PW            = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_t           phase,
    input  logic [PW-1:0]    period,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] trial_bits,
    output logic [NBITS-1:0] dout
);

    localparam logic [PW-1:0]    P_TRACK_END = PW'(TRACK_PERIODS);
    localparam logic [PW-1:0]    P_FIRST     = PW'(TRACK_PERIODS + 1);
    localparam logic [PW-1:0]    P_LAST      = PW'(TRACK_PERIODS + NBITS);
    localparam logic [NBITS-1:0] MSB_ONLY    = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] sar_q;
    logic [NBITS-1:0] dout_q;
    logic [NBITS-1:0] bit_mask;
    logic [NBITS-1:0] decided;

    // one-hot mask of the bit under test in the current period
    always_comb begin
        bit_mask = MSB_ONLY >> (period - P_FIRST);
        decided  = cmp_hi ? (sar_q | bit_mask) : (sar_q & ~bit_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q  <= '0;
            dout_q <= '0;
        end else if (phase == ST_TRACK && period == P_TRACK_END) begin
            sar_q <= MSB_ONLY;
        end else if (phase == ST_TRIAL) begin
            if (period == P_LAST) begin
                dout_q <= decided;
                sar_q  <= '0;
            end else begin
                sar_q <= decided | (bit_mask >> 1);
            end
        end
    end

    assign trial_bits = sar_q;
    assign dout       = dout_q;

    a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_TRIAL && period == P_FIRST) |-> (sar_q == MSB_ONLY));

    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !(phase == ST_TRIAL && period == P_LAST) |=> $stable(dout_q));

    a_r3_no_trial_while_tracking: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_TRIAL) |-> (sar_q == '0 || period == P_TRACK_END + PW'(1)));

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_seq_pkg::*;
#(
    parameter int NBITS         = 12,
    parameter int TRACK_PERIODS = 3,
    parameter int PW            = $clog2(TRACK_PERIODS + NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             ext_clk_mode,
    input  logic             cmp_hi,
    output logic             track_en,
    output logic             autozero_en,
    output logic [NBITS-1:0] trial_bits,
    output logic [NBITS-1:0] dout,
    output logic             drdy,
    output logic             clk_en,
    output logic [PW-1:0]    period
);

    phase_t        phase;
    logic [PW-1:0] period_w;
    logic          track_w;

    sar_phase_ctrl #(
        .TRACK_PERIODS (TRACK_PERIODS),
        .NBITS         (NBITS),
        .PW            (PW)
    ) u_phase (
        .clk          (clk),
        .rst          (rst),
        .start_n      (start_n),
        .ext_clk_mode (ext_clk_mode),
        .phase        (phase),
        .period       (period_w),
        .drdy         (drdy),
        .clk_en       (clk_en),
        .track_en     (track_w)
    );

    sar_bit_trial #(
        .NBITS         (NBITS),
        .TRACK_PERIODS (TRACK_PERIODS),
        .PW            (PW)
    ) u_trial (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .period     (period_w),
        .cmp_hi     (cmp_hi),
        .trial_bits (trial_bits),
        .dout       (dout)
    );

    assign track_en    = track_w;
    assign autozero_en = track_w;
    assign period      = period_w;

endmodule

// File: tb/tb_sar_sequencer.sv
module tb_sar_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b0;
    logic        ext_clk_mode = 1'b0;
    logic [11:0] target = '0;
    logic [11:0] prev = '0;
    logic        cmp_hi;
    logic        track_en, autozero_en, drdy, clk_en;
    logic [11:0] trial_bits, dout;
    logic [3:0]  period;
    int          n_chk = 0;
    int          n_bad = 0;

    // behavioural comparator: high when the held input is at or above the trial level
    assign cmp_hi = (target >= trial_bits);

    sar_sequencer dut (
        .clk          (clk),
        .rst          (rst),
        .start_n      (start_n),
        .ext_clk_mode (ext_clk_mode),
        .cmp_hi       (cmp_hi),
        .track_en     (track_en),
        .autozero_en  (autozero_en),
        .trial_bits   (trial_bits),
        .dout         (dout),
        .drdy         (drdy),
        .clk_en       (clk_en),
        .period       (period)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        check("R1 period", 32'(period), 1);
        check("R1 result", 32'(dout), 0);
        check("R1 ready", 32'(drdy), 0);
        check("R1 trial", 32'(trial_bits), 0);
        check("R3 track in reset", 32'(track_en), 1);
        rst = 1'b0;
    endtask

    // one conversion with start held low from period 1
    task automatic t_convert(input logic [11:0] tgt);
        target = tgt;
        for (int k = 1; k <= 15; k++) begin
            check("R2 period", 32'(period), 32'(k));
            check("R3 track", 32'(track_en), (k <= 3) ? 1 : 0);
            check("R3 autozero", 32'(autozero_en), (k <= 3) ? 1 : 0);
            if (k == 2) check("R7 ready falls", 32'(drdy), 0);
            if (k == 4) check("R4 msb trial", 32'(trial_bits), 32'h800);
            if (k == 5) check("R5 second trial", 32'(trial_bits), 32'((tgt & 12'h800) | 12'h400));
            if (k > 1)  check("R6 result held", 32'(dout), 32'(prev));
            step();
        end
        check("R5 result", 32'(dout), 32'(tgt));
        check("R7 ready rises", 32'(drdy), 1);
        check("R11 wrap to 1", 32'(period), 1);
        prev = tgt;
    endtask

    // park in period 2, then resume
    task automatic t_park(input logic mode, input logic [11:0] tgt);
        ext_clk_mode = mode;
        target = tgt;
        start_n = 1'b1;
        step();
        check("R8 parked period", 32'(period), 2);
        check("R8 ready held", 32'(drdy), 1);
        check("R8 tracking", 32'(track_en), 1);
        check("R9 clk_en parked", 32'(clk_en), 32'(mode));
        repeat (4) step();
        check("R8 still parked", 32'(period), 2);
        check("R8 result kept", 32'(dout), 32'(prev));
        check("R8 ready kept", 32'(drdy), 1);
        start_n = 1'b0;
        #1;
        check("R9 clk_en on start", 32'(clk_en), 1);
        @(negedge clk);
        check("R8 no advance without edge data", 32'(period), 32'(mode ? 3 : 3));
        for (int k = 4; k <= 15; k++) begin
            step();
            check("R10 resumed period", 32'(period), 32'(k));
            check("R6 result held", 32'(dout), 32'(prev));
        end
        step();
        check("R10 result", 32'(dout), 32'(tgt));
        check("R10 ready", 32'(drdy), 1);
        ext_clk_mode = 1'b0;
        prev = tgt;
    endtask

    // start toggled mid-conversion is ignored
    task automatic t_start_ignored(input logic [11:0] tgt);
        target = tgt;
        start_n = 1'b0;
        step();
        check("R12 running period 2", 32'(period), 2);
        start_n = 1'b1;
        for (int k = 3; k <= 15; k++) begin
            step();
            check("R12 period advances", 32'(period), 32'(k));
            start_n = (k % 2 == 0);
        end
        start_n = 1'b1;
        step();
        check("R12 result", 32'(dout), 32'(tgt));
        step();
        check("R12 parks after", 32'(period), 2);
        start_n = 1'b0;
        step();
        check("R10 resume to 3", 32'(period), 3);
        check("R10 track on", 32'(track_en), 1);
        check("R7 ready low", 32'(drdy), 0);
        repeat (13) step();
        check("R11 period 1", 32'(period), 1);
        prev = target;
    endtask

    initial begin
        #(20ns * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_convert(12'd0);
        t_convert(12'd4095);
        t_convert(12'h555);
        t_convert(12'hAAA);
        t_convert(12'd2048);
        t_convert(12'd1);
        t_convert(12'd2047);
        t_park(1'b0, 12'd1234);
        t_convert(12'd3072);
        t_park(1'b1, 12'd4094);
        t_start_ignored(12'd777);
        t_convert(12'd1024);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule